// File: doc/BRIEF.md
# Tracking Converter Counter with Dither Suppression

This block is the digital half of a tracking analog-to-digital converter. A saturating up/down counter drives an external DAC and steps by one code on every clock. A one-bit comparator input sets the direction: the counter climbs while the analog input sits above the DAC level and falls otherwise. The counter value is a fresh result on every clock, so it needs no end-of-conversion capture. After a large jump in the input the count still moves only one code per clock, so recovery from a step is slow.

With a steady input the counter alternates between two adjacent codes on every clock. A second output register hides that alternation. A run detector watches the direction of each step and lets the register load only when the counter has moved in the same direction on at least `RUN_MIN` consecutive steps. Each load raises a one-cycle update strobe. The comparator is asynchronous to the clock and passes through a flop synchronizer before the counter uses it.

Top module: `trk_adc`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `dac_code`, `stable_code` and `stable_upd` are all zero.
- R2: A high level on `comp_in` raises `dac_code` by exactly one. The change appears at the third rising clock edge after `comp_in` is applied: two edges in the synchronizer and one in the counter.
- R3: A low level on `comp_in` lowers `dac_code` by exactly one, with the same latency as R2.
- R4: At full scale (all ones), a high comparator level leaves `dac_code` unchanged. The counter never wraps to zero.
- R5: At zero, a low comparator level leaves `dac_code` unchanged. The counter never wraps to full scale.
- R6: When the step direction reverses on every clock, `stable_code` keeps its value and `stable_upd` stays low.
- R7: When a step completes a run of `RUN_MIN` (default 2) same-direction steps, `stable_code` takes the new `dac_code` value on the next edge and `stable_upd` is high for that one cycle. A reversal restarts the run at length one.
- R8: Every further step in the same direction after the run length is reached loads `stable_code` again and pulses `stable_upd` again.
- R9: A cycle in which the counter holds at zero or full scale is not a step. It neither loads `stable_code` nor pulses `stable_upd`, and it does not lengthen the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| comp_in | input | 1 | Comparator result: 1 means the analog input is above the DAC level |
| dac_code | output | WIDTH | Raw tracking count; drives the DAC |
| stable_code | output | WIDTH | Dither-suppressed result |
| stable_upd | output | 1 | One-cycle pulse when `stable_code` is loaded |

## Verification
The bench builds the block with `WIDTH` = 4, `RUN_MIN` = 2 and `SYNC_STAGES` = 2. The 16-code range makes both saturation rails reachable within about twenty clocks of ramping, so the bench can drive full-scale and zero holds, reversals away from a rail, and long same-direction runs in a short run. With a run threshold of two, a single reversal followed by one repeated step is the smallest pattern that produces a load. This separates the suppressed dither from a genuine move by one step.

// File: rtl/trk_pkg.sv
package trk_pkg;

    // Direction of the most recent counter update
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2
    } step_e;

    // Resolves the requested direction against the saturation rails
    function automatic step_e pick_step(input logic want_up,
                                        input logic at_top,
                                        input logic at_bot);
        step_e s;
        if (want_up)
            s = at_top ? STEP_NONE : STEP_UP;
        else
            s = at_bot ? STEP_NONE : STEP_DN;
        return s;
    endfunction

endpackage

// File: rtl/trk_sync.sv
module trk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/trk_counter.sv
module trk_counter
    import trk_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_up,
    output logic [WIDTH-1:0] code,
    output step_e            last_step
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    step_e nxt_step;

    always_comb begin
        nxt_step = pick_step(go_up, code == TOP, code == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code      <= '0;
            last_step <= STEP_NONE;
        end else begin
            last_step <= nxt_step;
            case (nxt_step)
                STEP_UP: code <= code + 1'b1;
                STEP_DN: code <= code - 1'b1;
                default: code <= code;
            endcase
        end
    end
endmodule

// File: rtl/trk_run_detect.sv
module trk_run_detect
    import trk_pkg::*;
#(
    parameter int RUN_MIN = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  step_e step,
    output logic  load
);
    localparam int LW = $clog2(RUN_MIN + 1);
    localparam logic [LW-1:0] LIMIT = LW'(RUN_MIN);

    step_e         prev_dir;
    logic [LW-1:0] run_len;
    logic [LW-1:0] nxt_len;
    logic          is_step;

    always_comb begin
        is_step = (step != STEP_NONE);
        if (step == prev_dir)
            nxt_len = (run_len == LIMIT) ? LIMIT : run_len + 1'b1;
        else
            nxt_len = LW'(1);
        load = is_step && (nxt_len >= LIMIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_dir <= STEP_NONE;
            run_len  <= '0;
        end else if (is_step) begin
            prev_dir <= step;
            run_len  <= nxt_len;
        end
    end
endmodule

// File: rtl/trk_adc.sv
module trk_adc
    import trk_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int RUN_MIN     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             comp_in,
    output logic [WIDTH-1:0] dac_code,
    output logic [WIDTH-1:0] stable_code,
    output logic             stable_upd
);
    logic  comp_s;
    step_e step;
    logic  load;

    trk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (comp_in),
        .q   (comp_s)
    );

    trk_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .go_up     (comp_s),
        .code      (dac_code),
        .last_step (step)
    );

    trk_run_detect #(.RUN_MIN(RUN_MIN)) u_run (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .load (load)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stable_code <= '0;
            stable_upd  <= 1'b0;
        end else begin
            stable_upd <= load;
            if (load) stable_code <= dac_code;
        end
    end
endmodule

// File: rtl/trk_adc_chk.sv
module trk_adc_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] dac_code,
    input logic [WIDTH-1:0] stable_code,
    input logic             stable_upd
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    // R2 / R3: the count moves by at most one code per clock
    p_single_step_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(dac_code) == dac_code) ||
        ({1'b0, $past(dac_code)} + 1 == {1'b0, dac_code}) ||
        ({1'b0, dac_code} + 1 == {1'b0, $past(dac_code)}));

    // R4: no wrap from full scale
    p_no_wrap_top_r4: assert property (@(posedge clk) disable iff (rst)
        dac_code == TOP |=> dac_code >= TOP - 1'b1);

    // R5: no wrap from zero
    p_no_wrap_bot_r5: assert property (@(posedge clk) disable iff (rst)
        dac_code == '0 |=> dac_code <= WIDTH'(1));

    // R7: a load captures the count present before the edge
    p_load_value_r7: assert property (@(posedge clk) disable iff (rst)
        stable_upd |-> stable_code == $past(dac_code));

    // R6: without a strobe the stabilised output stays put
    p_hold_stable_r6: assert property (@(posedge clk) disable iff (rst)
        !stable_upd |-> $stable(stable_code));
endmodule

bind trk_adc trk_adc_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dac_code    (dac_code),
    .stable_code (stable_code),
    .stable_upd  (stable_upd)
);

// File: tb/trk_adc_tb.sv
module trk_adc_tb;
    localparam int W       = 4;
    localparam int RUNMIN  = 2;
    localparam int MAXC    = (1 << W) - 1;

    typedef struct {
        int    code;
        int    stab;
        bit    upd;
        string req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         comp_in = 1'b0;
    logic [W-1:0] dac_code;
    logic [W-1:0] stable_code;
    logic         stable_upd;

    int   errors = 0;
    int   checks = 0;
    exp_t sbq[$];

    // model state, built from the requirements
    int m_s1, m_s2, m_code, m_step, m_prev, m_len, m_stab;
    bit m_upd;

    always #4 clk = ~clk;

    trk_adc #(.WIDTH(W), .RUN_MIN(RUNMIN), .SYNC_STAGES(2)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .comp_in     (comp_in),
        .dac_code    (dac_code),
        .stable_code (stable_code),
        .stable_upd  (stable_upd)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // step encodings inside the model: 0 none, 1 up, 2 down
    task automatic model_edge(input bit c);
        int  nlen;
        bit  load;
        nlen = (m_step == m_prev) ? ((m_len >= RUNMIN) ? RUNMIN : m_len + 1) : 1;
        load = (m_step != 0) && (nlen >= RUNMIN);
        m_upd = load;
        if (load) m_stab = m_code;
        if (m_step != 0) begin
            m_prev = m_step;
            m_len  = nlen;
        end
        if (m_s2 == 1 && m_code < MAXC) begin
            m_code = m_code + 1; m_step = 1;
        end else if (m_s2 == 0 && m_code > 0) begin
            m_code = m_code - 1; m_step = 2;
        end else begin
            m_step = 0;
        end
        m_s2 = m_s1;
        m_s1 = c;
    endtask

    // driver: called just after a falling edge
    task automatic drive(input bit c, input string req);
        exp_t e;
        comp_in = c;
        @(posedge clk);
        model_edge(c);
        e.code = m_code; e.stab = m_stab; e.upd = m_upd; e.req = req;
        sbq.push_back(e);
        @(negedge clk);
    endtask

    // monitor: compares outputs against queued expectations
    always @(negedge clk) begin
        if (!rst && sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            check(e.req, "dac_code", int'(dac_code), e.code);
            check(e.req, "stable_code", int'(stable_code), e.stab);
            check(e.req, "stable_upd", int'(stable_upd), int'(e.upd));
        end
    end

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_s1 = 0; m_s2 = 0; m_code = 0; m_step = 0; m_prev = 0; m_len = 0; m_stab = 0; m_upd = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: values held in reset
        check("R1", "dac_code in reset", int'(dac_code), 0);
        check("R1", "stable_upd in reset", int'(stable_upd), 0);
        rst = 1'b0;
        // R1: first cycle after release (handled by scoreboard too)
        drive(1'b1, "R1");
        check("R1", "stable_code after release", int'(stable_code), 0);
        // R2 ramp up then R4 hold at full scale
        for (int i = 0; i < 24; i++) drive(1'b1, (i < 14) ? "R2" : "R4");
        // R3 ramp down then R5/R9 hold at zero
        for (int i = 0; i < 24; i++) drive(1'b0, (i < 14) ? "R3" : ((i < 20) ? "R5" : "R9"));
        // R6 dither around the bottom
        for (int i = 0; i < 14; i++) drive(i[0] ? 1'b0 : 1'b1, "R6");
        // R7 one repeated step after dither, then reversal restart
        drive(1'b1, "R7"); drive(1'b1, "R7"); drive(1'b1, "R7");
        drive(1'b0, "R7"); drive(1'b1, "R7"); drive(1'b0, "R7");
        drive(1'b0, "R7"); drive(1'b1, "R7");
        for (int i = 0; i < 6; i++) drive(i[0] ? 1'b1 : 1'b0, "R6");
        // R8 long run upward
        for (int i = 0; i < 8; i++) drive(1'b1, "R8");
        // R9 run into full scale, hold, reverse away
        for (int i = 0; i < 16; i++) drive(1'b1, "R9");
        drive(1'b0, "R9"); drive(1'b1, "R9"); drive(1'b0, "R9");
        drive(1'b0, "R9"); drive(1'b0, "R9");
        for (int i = 0; i < 6; i++) drive(1'b0, "R3");
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule